// File: doc/BRIEF.md
# Network Status LED Controller

This block drives one three-colour status LED for an Ethernet port. Its inputs are the sampled link state and speed, single-cycle transmit and receive activity pulses, a mode select and a 1 ms tick. Its output is a 2-bit colour code. With no link the LED is red. With a link it is orange at 10 Mbit/s and green at 100 Mbit/s whenever it is lit.

Activity is stretched into a flash that lasts a minimum number of ticks. The flash can only end on a slower evaluation strobe, so its length is rounded up to that strobe. A dark hold-off gap follows every flash. Because of this, continuous traffic still appears as distinct blinks. In link mode the LED is lit while idle and goes dark during a flash. In activity mode the LED is dark while idle and lights during a flash. A change of link state or speed cancels any flash at once, so the LED shows the idle look for the new state in the same cycle.

Top module: `net_led_ctrl`

## Requirements
- R1: When link_up_i is 0, color_o is 2'b01 (red), whatever the activity, flash state and mode.
- R2: With link up, a lit LED shows 2'b11 (green) when speed_100_i is 1 and 2'b10 (orange) when it is 0. A dark LED shows 2'b00.
- R3: When mode_act_i is 0 (link mode), the LED is lit while idle and dark during a flash. When mode_act_i is 1 (activity mode), it is dark while idle and lit during a flash.
- R4: A tx_act_i or rx_act_i pulse starts a flash at the next clock edge. This happens only if the link is up, no flash is active and the hold-off count is zero.
- R5: The evaluation strobe falls on every EVAL_TICKS-th tick counted from reset. A flash ends at the first strobe whose tick finds at least ON_TICKS ticks already counted since the flash started.
- R6: When a flash ends, a hold-off of OFF_TICKS ticks begins. No flash can start until that count has run out.
- R7: Activity pulses that arrive during a flash, during the hold-off or while the link is down are dropped and are not queued.
- R8: A change of link_up_i or speed_100_i from its value in the previous cycle shows the idle appearance in that same cycle. It also cancels the flash and clears the hold-off.
- R9: After reset no flash is active, the hold-off has expired, the evaluation count is zero and the link is treated as down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 ms tick |
| link_up_i | input | 1 | Sampled link state |
| speed_100_i | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| tx_act_i | input | 1 | Transmit activity pulse |
| rx_act_i | input | 1 | Receive activity pulse |
| mode_act_i | input | 1 | 0 = link mode, 1 = activity mode |
| color_o | output | 2 | 00 off, 01 red, 10 orange, 11 green |

## Verification
The colour output is combinational from the current link, speed and mode inputs and the registered flash state. A link or speed change therefore shows in the same cycle it is applied. A flash start shows one edge after its activity pulse. A flash end shows one edge after the strobing tick. The bench drives inputs just after the falling edge and samples color_o 1 ns later. It then advances its own requirement-level model by one edge, so every expected value is due in exactly the cycle being checked. Random ticks, pulses and link, speed and mode flips run with short interval parameters, after directed colour, mode and flash-overlap cases.

// File: rtl/net_led_pkg.sv
package net_led_pkg;
  typedef enum logic [1:0] {
    LED_OFF    = 2'b00,
    LED_RED    = 2'b01,
    LED_ORANGE = 2'b10,
    LED_GREEN  = 2'b11
  } led_color_e;
endpackage

// File: rtl/led_eval_timer.sv
module led_eval_timer #(
  parameter int unsigned EVAL_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic eval_o
);
  localparam int unsigned EW = (EVAL_TICKS > 1) ? $clog2(EVAL_TICKS) : 1;
  localparam logic [EW-1:0] LAST = EW'(EVAL_TICKS - 1);

  logic [EW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (tick_i && cnt_q == LAST) cnt_q <= '0;
    else if (tick_i)                cnt_q <= cnt_q + EW'(1);
  end

  assign eval_o = tick_i && (cnt_q == LAST);

  // R5
  eval_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/led_state_watch.sv
module led_state_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_up_i,
  input  logic speed_100_i,
  output logic chg_o
);
  logic link_q, spd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      spd_q  <= 1'b0;
    end else begin
      link_q <= link_up_i;
      spd_q  <= speed_100_i;
    end
  end

  assign chg_o = (link_q != link_up_i) || (spd_q != speed_100_i);
endmodule

// File: rtl/led_flash_ctrl.sv
module led_flash_ctrl #(
  parameter int unsigned ON_TICKS  = 20,
  parameter int unsigned OFF_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic eval_i,
  input  logic act_i,
  input  logic link_up_i,
  input  logic chg_i,
  output logic flash_o
);
  localparam int unsigned OW = $clog2(ON_TICKS + 1);
  localparam int unsigned HW = $clog2(OFF_TICKS + 1);
  localparam logic [OW-1:0] ON_MAX  = OW'(ON_TICKS);
  localparam logic [HW-1:0] OFF_LD  = HW'(OFF_TICKS);

  logic          flash_q;
  logic [OW-1:0] on_cnt_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flash_q  <= 1'b0;
      on_cnt_q <= '0;
      hold_q   <= '0;
    end else if (chg_i) begin
      flash_q  <= 1'b0;
      on_cnt_q <= '0;
      hold_q   <= '0;
    end else if (flash_q) begin
      if (tick_i) begin
        if (eval_i && on_cnt_q == ON_MAX) begin
          flash_q <= 1'b0;
          hold_q  <= OFF_LD;
        end else if (on_cnt_q != ON_MAX) begin
          on_cnt_q <= on_cnt_q + OW'(1);
        end
      end
    end else begin
      if (tick_i && hold_q != '0) hold_q <= hold_q - HW'(1);
      if (act_i && link_up_i && hold_q == '0) begin
        flash_q  <= 1'b1;
        on_cnt_q <= '0;
      end
    end
  end

  assign flash_o = flash_q;

  // R5
  flash_end_on_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_q) && !$past(chg_i) |-> $past(eval_i));
  // R6
  start_after_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_q) |-> $past(hold_q) == '0);
  // R7
  start_needs_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_q) |-> $past(link_up_i) && $past(act_i));
  // R8
  chg_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> !flash_q && hold_q == '0);
  // R5
  on_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_cnt_q <= ON_MAX);
endmodule

// File: rtl/net_led_ctrl.sv
module net_led_ctrl
  import net_led_pkg::*;
#(
  parameter int unsigned ON_TICKS   = 20,
  parameter int unsigned OFF_TICKS  = 10,
  parameter int unsigned EVAL_TICKS = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       link_up_i,
  input  logic       speed_100_i,
  input  logic       tx_act_i,
  input  logic       rx_act_i,
  input  logic       mode_act_i,
  output logic [1:0] color_o
);
  logic eval, chg, flash, flash_eff, lit;
  led_color_e color;

  led_eval_timer #(.EVAL_TICKS(EVAL_TICKS)) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .eval_o(eval)
  );

  led_state_watch u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_up_i(link_up_i),
    .speed_100_i(speed_100_i), .chg_o(chg)
  );

  led_flash_ctrl #(.ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_flash (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .eval_i(eval),
    .act_i(tx_act_i | rx_act_i), .link_up_i(link_up_i), .chg_i(chg),
    .flash_o(flash)
  );

  // a state change shows idle at once, before the flash register clears
  assign flash_eff = flash & ~chg;
  assign lit       = mode_act_i ? flash_eff : ~flash_eff;

  always_comb begin
    if (!link_up_i)    color = LED_RED;
    else if (!lit)     color = LED_OFF;
    else if (speed_100_i) color = LED_GREEN;
    else               color = LED_ORANGE;
  end

  assign color_o = color;

  // R1
  link_down_red_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |-> color_o == LED_RED);
  // R8
  chg_idle_look_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_i && chg |-> (color_o == LED_OFF) == mode_act_i);
endmodule

// File: tb/test_net_led_ctrl.sv
`timescale 1ns/1ps
module test_net_led_ctrl;
  localparam int ON = 4, OFF = 3, EV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, link = 0, spd = 0, tx = 0, rx = 0, mode = 0;
  logic [1:0] color;
  int nchk = 0, nfail = 0;

  // reference model state
  logic m_link = 0, m_spd = 0, m_flash = 0;
  int m_on = 0, m_hold = 0, m_eval = 0;
  bit prev_ign = 0, prev_start = 0;

  always #2.5 clk = ~clk;

  net_led_ctrl #(.ON_TICKS(ON), .OFF_TICKS(OFF), .EVAL_TICKS(EV)) i_net_led_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .link_up_i(link),
    .speed_100_i(spd), .tx_act_i(tx), .rx_act_i(rx), .mode_act_i(mode),
    .color_o(color)
  );

  task automatic check(input logic [1:0] exp, input string tag);
    nchk++;
    if (color !== exp) begin
      nfail++;
      $display("FAIL %s color=%b expected=%b at %0t", tag, color, exp, $time);
    end
  endtask

  task automatic step(input logic tk, lk, sp, md, t, r, input string tag);
    logic chg, eff, lit, act, ev;
    logic [1:0] exp;
    string tg;
    @(negedge clk);
    tick = tk; link = lk; spd = sp; mode = md; tx = t; rx = r;
    #1;
    chg = (lk != m_link) || (sp != m_spd);
    eff = m_flash && !chg;
    lit = md ? eff : !eff;
    exp = !lk ? 2'b01 : !lit ? 2'b00 : sp ? 2'b11 : 2'b10;
    if (tag != "") tg = tag;
    else if (!lk) tg = "R1";
    else if (chg) tg = "R8";
    else if (prev_start) tg = "R4";
    else if (prev_ign) tg = "R7";
    else if (m_flash) tg = "R5";
    else if (m_hold != 0) tg = "R6";
    else tg = md ? "R3" : "R2";
    check(exp, tg);
    act = t | r;
    ev = tk && (m_eval == EV - 1);
    prev_ign = act && !chg && (m_flash || m_hold != 0 || !lk);
    prev_start = 0;
    if (tk) m_eval = (m_eval == EV - 1) ? 0 : m_eval + 1;
    m_link = lk; m_spd = sp;
    if (chg) begin
      m_flash = 0; m_on = 0; m_hold = 0;
    end else if (m_flash) begin
      if (tk) begin
        if (ev && m_on == ON) begin m_flash = 0; m_hold = OFF; end
        else if (m_on < ON) m_on++;
      end
    end else begin
      if (act && lk && m_hold == 0) begin
        m_flash = 1; m_on = 0; prev_start = 1;
      end
      if (tk && m_hold != 0) m_hold--;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic lk, sp, md;
    void'($urandom(32'h1ed5));
    repeat (3) @(negedge clk);
    check(2'b01, "R9");
    rst_n = 1'b1;
    // R9: link down after reset, activity ignored
    step(1, 0, 0, 0, 1, 0, "R1");
    step(0, 0, 1, 1, 0, 1, "R1");
    // R2, R3 idle colours
    step(0, 1, 1, 0, 0, 0, "R8");
    step(0, 1, 1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    // R4 start in link mode, R7 pulses during flash, R5 end, R6 hold-off
    step(0, 1, 1, 0, 1, 0, "R8");
    step(0, 1, 1, 0, 1, 0, "R4");
    for (int i = 0; i < 40; i++) step(i % 2 == 0, 1, 1, 0, i % 3 == 0, i % 5 == 0, "");
    // R8 speed change during a flash
    step(0, 1, 1, 1, 1, 0, "");
    step(0, 1, 1, 1, 0, 0, "R4");
    step(0, 1, 0, 1, 0, 0, "R8");
    step(0, 1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 20000; i++) begin
      lk = ($urandom % 400 == 0) ? ~link : link;
      sp = ($urandom % 300 == 0) ? ~spd : spd;
      md = ($urandom % 500 == 0) ? ~mode : mode;
      step($urandom % 3 == 0, lk, sp, md, $urandom % 6 == 0, $urandom % 7 == 0, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule